// File: doc/BRIEF.md
# Parallel-to-Serial Scan Bandwidth Matcher

This block sits between a wide test-data channel and a set of wrapper scan chains. It accepts a data word through a valid/ready handshake and slices it into scan slices. Each slice is as wide as the number of chains currently in use. Every bit of every accepted word reaches a chain, so the channel only has to carry as many bits as the chains consume.

A load/shift register takes the whole word in one cycle. It then moves one bit per cycle, lowest index first, into a shift-only slice buffer. The buffer has one position per chain. When the buffer holds as many bits as there are chains, the block issues a single scan pulse that presents the slice. The buffer then starts filling again.

Bits left over at the end of a word stay in the buffer and combine with the first bits of the next word. A capture input holds back scan pulses. A full buffer therefore keeps the first slice of the next pattern while capture is applied. The chain count is a runtime setting from 1 up to the word width. It must be stable while data is in flight.

Top module: `scan_bw_matcher`

## Requirements
- R1: After synchronous reset, in_ready is 1, scan_en is 0 and scan_slice is all zeros.
- R2: A word is accepted in a cycle where in_valid and in_ready are both 1. in_ready then stays 0 until every bit of that word has moved into the slice buffer.
- R3: In each cycle that neither scans nor stalls, exactly one bit moves from the load register into the buffer. Bits move in index order from bit 0 upward. The k-th bit moved since the last scan lands at slice position k (position 0 feeds chain 0). The buffer never holds more bits than the chain count.
- R4: When the buffer holds chain-count bits and capture is 0, the next cycle shows scan_en = 1 for exactly one cycle together with the slice. No bit moves in the cycle that issues the scan.
- R5: Joined in scan order, the scan slices reproduce the accepted input bit stream exactly, with no gaps, repeats or reordering.
- R6: When the word width is not a multiple of the chain count, the leftover bits stay in the buffer. They are scanned together with the first bits of the next word.
- R7: When the word width is a multiple of the chain count, each word yields exactly width / count scans and leaves nothing in the buffer.
- R8: While capture is 1, no scan pulse is issued and the buffered slice is kept. The held slice is the one presented on the first scan after capture returns to 0.
- R9: On a scan pulse, slice bits at positions equal to or above the chain count are 0.
- R10: Chain counts of 1 and of the full word width both work. A count of 1 gives one scan per bit; the full width gives one scan per word, equal to the word.
- R11: in_ready returns to 1 in the cycle right after the last bit of the word moves. With a chain count equal to the word width, in_ready is 0 for exactly word-width cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chains | input | CNT_W | Number of active scan chains, 1 to WORD_W |
| in_data | input | WORD_W | Incoming test-data word |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | Block can take a word this cycle |
| capture | input | 1 | Capture in progress; holds back scan pulses |
| scan_slice | output | WORD_W | One bit per chain, registered |
| scan_en | output | 1 | One-cycle scan pulse for the wrapper chains, registered |

## Verification
The assertions check, on every cycle, four properties: the buffer never overfills, a scan pulse is never two cycles long, no scan follows a capture cycle, and slice bits above the chain count are zero. They also check that a handshake drops in_ready and that in_ready returns right after the last bit moves. Only the bench scenarios can show the data-path properties: the slices reproduce the bit stream in order, leftover bits carry into the next word, a held slice survives capture, and the scan counts are right for chain counts that divide the word, leave a remainder, are 1, or equal the word width.

// File: rtl/scan_bw_pkg.sv
package scan_bw_pkg;
  typedef enum logic [1:0] {
    SBM_HOLD  = 2'd0,
    SBM_SHIFT = 2'd1,
    SBM_SCAN  = 2'd2
  } sbm_act_e;
endpackage

// File: rtl/sbm_load_shift.sv
module sbm_load_shift #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              shift,
  output logic              bit_out,
  output logic              empty
);
  logic [WORD_W-1:0] hold_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      left_q <= '0;
    end else if (load) begin
      hold_q <= word;
      left_q <= CNT_W'(WORD_W);
    end else if (shift) begin
      hold_q <= hold_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_out = hold_q[0];
  assign empty   = (left_q == '0);

  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !empty);

  // R11
  ready_return_chk: assert property (@(posedge clk) disable iff (rst)
    (left_q == CNT_W'(1) && shift && !load) |=> empty);
endmodule

// File: rtl/sbm_slice_buf.sv
module sbm_slice_buf #(
  parameter int MAX_CH = 8,
  parameter int CNT_W  = $clog2(MAX_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  nch,
  input  logic              push,
  input  logic              bit_in,
  input  logic              drain,
  output logic [MAX_CH-1:0] slice,
  output logic [CNT_W-1:0]  fill
);
  logic [CNT_W-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst || drain) fill_q <= '0;
    else if (push)    fill_q <= fill_q + 1'b1;
  end

  for (genvar g = 0; g < MAX_CH; g++) begin : g_pos
    logic pos_q;
    always_ff @(posedge clk) begin
      if (rst || drain)                     pos_q <= 1'b0;
      else if (push && fill_q == CNT_W'(g)) pos_q <= bit_in;
    end
    assign slice[g] = pos_q;
  end

  assign fill = fill_q;

  // R3
  fill_limit_chk: assert property (@(posedge clk) disable iff (rst)
    fill_q <= nch);

  // R4
  push_drain_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && drain));
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
  import scan_bw_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] nch,
  input  logic             src_empty,
  input  logic             capture,
  input  logic             in_valid,
  output sbm_act_e         act,
  output logic             do_load,
  output logic             ready
);
  always_comb begin
    if (fill == nch && !capture)       act = SBM_SCAN;
    else if (!src_empty && fill < nch) act = SBM_SHIFT;
    else                               act = SBM_HOLD;
  end

  assign ready   = src_empty;
  assign do_load = src_empty && in_valid;
endmodule

// File: rtl/scan_bw_matcher.sv
module scan_bw_matcher
  import scan_bw_pkg::*;
#(
  parameter int  WORD_W = 8,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_chains,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              capture,
  output logic [WORD_W-1:0] scan_slice,
  output logic              scan_en
);
  localparam int MAX_CH = WORD_W;

  sbm_act_e          act;
  logic              do_load, src_empty, src_bit;
  logic [CNT_W-1:0]  fill;
  logic [MAX_CH-1:0] buf_slice;
  logic [MAX_CH-1:0] hi_mask;

  sbm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .fill(fill), .nch(cfg_chains), .src_empty(src_empty), .capture(capture),
    .in_valid(in_valid), .act(act), .do_load(do_load), .ready(in_ready)
  );

  sbm_load_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_src (
    .clk(clk), .rst(rst), .load(do_load), .word(in_data),
    .shift(act == SBM_SHIFT), .bit_out(src_bit), .empty(src_empty)
  );

  sbm_slice_buf #(.MAX_CH(MAX_CH), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst(rst), .nch(cfg_chains), .push(act == SBM_SHIFT),
    .bit_in(src_bit), .drain(act == SBM_SCAN), .slice(buf_slice), .fill(fill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_en    <= 1'b0;
      scan_slice <= '0;
    end else begin
      scan_en <= (act == SBM_SCAN);
      if (act == SBM_SCAN) scan_slice <= buf_slice;
    end
  end

  always_comb begin
    for (int i = 0; i < MAX_CH; i++) hi_mask[i] = (CNT_W'(i) >= cfg_chains);
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> !scan_en);

  // R8
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> !scan_en);

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> ((scan_slice & hi_mask) == '0));

  // R10
  cfg_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_chains != '0) && (cfg_chains <= CNT_W'(WORD_W)));
endmodule

// File: tb/scan_bw_matcher_tb.sv
module scan_bw_matcher_tb;
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cfg_chains = CW'(3);
  logic [W-1:0]  in_data = '0;
  logic          in_valid = 1'b0;
  logic          capture = 1'b0;
  logic          in_ready, scan_en;
  logic [W-1:0]  scan_slice;

  always #5 clk = ~clk;

  scan_bw_matcher #(.WORD_W(W)) u_dut (
    .clk(clk), .rst(rst), .cfg_chains(cfg_chains), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .capture(capture),
    .scan_slice(scan_slice), .scan_en(scan_en)
  );

  int checks = 0, fails = 0, scans = 0, nch = 3;
  bit done = 0;
  bit m_src[$];
  bit m_buf[$];
  bit sent[$];
  logic         exp_en = 1'b0;
  logic [W-1:0] exp_slice = '0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: bit queues stepped on each rising edge
  always @(posedge clk) begin
    bit dsc, dsh, dld;
    if (rst) begin
      m_src.delete(); m_buf.delete(); exp_en = 1'b0; exp_slice = '0;
    end else begin
      dsc = (m_buf.size() == nch) && !capture;
      dsh = !dsc && (m_src.size() > 0) && (m_buf.size() < nch);
      dld = (m_src.size() == 0) && in_valid;
      exp_en = dsc;
      if (dsc) begin
        exp_slice = '0;
        foreach (m_buf[i]) exp_slice[i] = m_buf[i];
        m_buf.delete();
      end
      if (dsh) m_buf.push_back(m_src.pop_front());
      if (dld) for (int i = 0; i < W; i++) m_src.push_back(in_data[i]);
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(in_ready === (m_src.size() == 0), "R2 in_ready", in_ready, m_src.size() == 0);
      chk(scan_en === exp_en, "R4 scan_en", scan_en, exp_en);
      if (exp_en) chk(scan_slice === exp_slice, "R3 R9 slice", scan_slice, exp_slice);
      if (scan_en) begin
        scans++;
        for (int i = 0; i < nch; i++) begin
          if (sent.size() == 0) chk(0, "R5 stream underrun", i, -1);
          else begin
            bit e;
            e = sent.pop_front();
            chk(scan_slice[i] === e, "R5 stream bit", scan_slice[i], e);
          end
        end
      end
    end
  end

  task automatic start(int n);
    rst = 1'b1; nch = n; cfg_chains = CW'(n); capture = 1'b0; in_valid = 1'b0;
    sent.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    scans = 0;
  endtask

  task automatic send(logic [W-1:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = w; in_valid = 1'b1;
    for (int i = 0; i < W; i++) sent.push_back(w[i]);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lowc;
    // R1 reset state
    start(3);
    @(negedge clk);
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    chk(scan_en === 1'b0, "R1 scan_en", scan_en, 0);
    chk(scan_slice === '0, "R1 scan_slice", scan_slice, 0);

    // R6 leftover with 3 chains
    send(8'hA5);
    repeat (20) @(negedge clk);
    chk(scans == 2, "R6 scans after first word", scans, 2);
    chk(sent.size() == 2, "R6 bits held in buffer", sent.size(), 2);
    send(8'h3C);
    repeat (20) @(negedge clk);
    chk(scans == 5, "R6 scans after second word", scans, 5);

    // R7 exact multiple with 4 chains
    start(4);
    send(8'h96); send(8'h0F); send(8'hE1);
    repeat (30) @(negedge clk);
    chk(scans == 6, "R7 scan count", scans, 6);
    chk(sent.size() == 0, "R7 no carry", sent.size(), 0);

    // R10 one chain
    start(1);
    send(8'h5B); send(8'hC4);
    repeat (40) @(negedge clk);
    chk(scans == 16, "R10 one chain scans", scans, 16);

    // R10 full width, R11 ready latency
    start(W);
    send(8'h7E);
    lowc = 0;
    while (!in_ready && lowc < 100) begin lowc++; @(negedge clk); end
    chk(lowc == W, "R11 ready low cycles", lowc, W);
    send(8'h81);
    repeat (20) @(negedge clk);
    chk(scans == 2, "R10 full width scans", scans, 2);

    // R8 capture holds the full slice
    start(3);
    capture = 1'b1;
    send(8'hD2);
    repeat (20) @(negedge clk);
    chk(scans == 0, "R8 no scan under capture", scans, 0);
    chk(in_ready === 1'b0, "R8 stall keeps word", in_ready, 0);
    capture = 1'b0;
    repeat (20) @(negedge clk);
    chk(scans == 2, "R8 scans after release", scans, 2);

    // R5 long stream, 5 chains, back to back
    start(5);
    for (int k = 0; k < 20; k++) send(W'((k * 37 + 11) ^ (k << 3)));
    repeat (40) @(negedge clk);
    chk(scans == 32, "R5 stream scans", scans, 32);
    chk(sent.size() == 0, "R5 stream fully scanned", sent.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule